// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns a 6-bit operand specifier into a 32-bit operand address for a CPU core. The upper three bits of the specifier pick an addressing mode. The lower three bits pick a register, or a sub-mode when the upper field is all ones. The unit reads the data and address register values, the program counter and up to three extension words that the fetch stage has already collected. From these it forms base plus displacement plus scaled index. For postincrement and predecrement it also produces the address register write-back.

For each request the unit also reports the operand category flags: data, memory, control and alterable. It raises an illegal flag for specifiers and extension formats that have no meaning. The indexed modes take either a brief extension with an 8-bit displacement or a full extension with a base displacement of null, word or long size. The full form can suppress the base, so that the scaled index register alone serves as the pointer. All results are registered. They appear one clock after the request strobe.

Extension word 0 of an indexed mode is laid out as follows. Bit 15 selects the index register file (0 data, 1 address). Bits 14:12 give the index register number. Bit 11 gives the index size (0 sign-extended low word, 1 full long). Bits 10:9 give the scale as a shift of 0 to 3. Bit 8 selects the format (0 brief, 1 full). In the brief form, bits 7:0 hold the signed displacement. In the full form, bit 7 suppresses the base and bits 5:4 give the base displacement size (00 reserved, 01 null, 10 word taken from extension word 1, 11 long taken from extension words 1:2).

Top module: `ea_gen`

## Requirements
- R1: The class flags follow the mode:
  - data register direct (000) gives data and alterable;
  - address register direct (001) gives alterable only;
  - postincrement (011) and predecrement (100) give data, memory and alterable;
  - indirect (010), 16-bit displacement (101), indexed (110), absolute short (111/000) and absolute long (111/001) give all four flags;
  - PC displacement (111/010) and PC indexed (111/011) give data, memory and control;
  - immediate (111/100) gives data and memory.
- R2: Specifiers 111/101, 111/110 and 111/111, and any full-format indexed extension whose base displacement size is 00, raise illegal_o. In that case all class flags are clear, no write-back is requested and addr_o is 0.
- R3: Mode 010 yields the selected address register. Mode 101 yields that register plus extension word 0 sign-extended to 32 bits.
- R4: Postincrement yields the unmodified address register and writes back register + step. Predecrement yields register − step and writes back the same value. wb_en_o is set only for these two modes, and wb_reg_o is the register field.
- R5: The step is 1, 2 or 4 for operand size 00 (byte), 01 (word) and 10 or 11 (long). A byte access through address register 7 steps by 2.
- R6: Brief indexed mode yields base + sign-extended 8-bit displacement + (index << scale). The index is the selected data or address register, either whole or with its low word sign-extended.
- R7: Full indexed mode adds a base displacement of 0 (size 01), sign-extended extension word 1 (size 10) or {ext1, ext2} (size 11). When the suppress bit is set, the base contributes 0.
- R8: PC displacement yields pc_i + sign-extended extension word 0. PC indexed uses pc_i as the base with the same index rules as R6 and R7.
- R9: Absolute short yields extension word 0 sign-extended. Absolute long yields {ext0, ext1}.
- R10: Register direct modes and immediate yield addr_o = 0 with no write-back. Register direct modes never set the memory flag.
- R11: After reset all outputs are 0. valid_o follows valid_i by one clock. When valid_i is low, the next cycle has valid_o, wb_en_o and illegal_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| spec_i | input | 6 | Mode field [5:3], register field [2:0] |
| size_i | input | 2 | Operand size: 00 byte, 01 word, 1x long |
| dreg_i | input | 256 | Data registers, register k at bits [32k+31:32k] |
| areg_i | input | 256 | Address registers, same packing |
| pc_i | input | 32 | Address of the first extension word |
| ext0_i | input | 16 | Extension word 0 |
| ext1_i | input | 16 | Extension word 1 |
| ext2_i | input | 16 | Extension word 2 |
| valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Operand address |
| wb_en_o | output | 1 | Address register write-back request |
| wb_reg_o | output | 3 | Address register to write |
| wb_data_o | output | 32 | Write-back value |
| cls_data_o | output | 1 | Data category |
| cls_mem_o | output | 1 | Memory category |
| cls_ctrl_o | output | 1 | Control category |
| cls_alter_o | output | 1 | Alterable category |
| illegal_o | output | 1 | Illegal specifier or extension format |

## Verification
Every result, whether address, write-back or flags, is due on the first rising edge after the edge that sees valid_i high. No output depends on the request for more than that one registered cycle. The bench applies each request on a falling edge and reads the outputs on the next falling edge. That point lies half a period after the single register stage has loaded and before the following request can disturb it. Requests that drop valid_i are checked on the same one-edge schedule, to confirm that the strobe and the write-back request fall.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [3:0] {
    EA_DREG, EA_AREG, EA_IND, EA_POSTINC, EA_PREDEC, EA_DISP, EA_IDX,
    EA_ABSW, EA_ABSL, EA_PCDISP, EA_PCIDX, EA_IMM, EA_BAD
  } ea_mode_e;

  typedef struct packed {
    logic data;
    logic mem;
    logic ctrl;
    logic alter;
  } ea_class_t;

  localparam logic [1:0] BD_RSVD = 2'b00;
  localparam logic [1:0] BD_NULL = 2'b01;
  localparam logic [1:0] BD_WORD = 2'b10;
  localparam logic [1:0] BD_LONG = 2'b11;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_gen_pkg::*;
(
  input  logic [5:0] spec_i,
  output ea_mode_e   mode_o,
  output ea_class_t  cls_o
);
  always_comb begin
    case (spec_i[5:3])
      3'd0: mode_o = EA_DREG;
      3'd1: mode_o = EA_AREG;
      3'd2: mode_o = EA_IND;
      3'd3: mode_o = EA_POSTINC;
      3'd4: mode_o = EA_PREDEC;
      3'd5: mode_o = EA_DISP;
      3'd6: mode_o = EA_IDX;
      default: begin
        case (spec_i[2:0])
          3'd0:    mode_o = EA_ABSW;
          3'd1:    mode_o = EA_ABSL;
          3'd2:    mode_o = EA_PCDISP;
          3'd3:    mode_o = EA_PCIDX;
          3'd4:    mode_o = EA_IMM;
          default: mode_o = EA_BAD;
        endcase
      end
    endcase
  end

  always_comb begin
    case (mode_o)
      EA_DREG:               cls_o = '{data: 1'b1, mem: 1'b0, ctrl: 1'b0, alter: 1'b1};
      EA_AREG:               cls_o = '{data: 1'b0, mem: 1'b0, ctrl: 1'b0, alter: 1'b1};
      EA_POSTINC, EA_PREDEC: cls_o = '{data: 1'b1, mem: 1'b1, ctrl: 1'b0, alter: 1'b1};
      EA_PCDISP, EA_PCIDX:   cls_o = '{data: 1'b1, mem: 1'b1, ctrl: 1'b1, alter: 1'b0};
      EA_IMM:                cls_o = '{data: 1'b1, mem: 1'b1, ctrl: 1'b0, alter: 1'b0};
      EA_BAD:                cls_o = '0;
      default:               cls_o = '{data: 1'b1, mem: 1'b1, ctrl: 1'b1, alter: 1'b1};
    endcase
  end
endmodule

// File: rtl/ea_index.sv
module ea_index #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic [NREG*DW-1:0] dreg_i,
  input  logic [NREG*DW-1:0] areg_i,
  input  logic [15:0]        ext_i,
  output logic [DW-1:0]      idx_o
);
  logic [RIW-1:0] sel;
  logic [DW-1:0]  raw;
  logic [DW-1:0]  val;

  assign sel = ext_i[12 +: RIW];
  assign raw = ext_i[15] ? areg_i[sel*DW +: DW] : dreg_i[sel*DW +: DW];
  assign val = ext_i[11] ? raw : {{(DW-16){raw[15]}}, raw[15:0]};
  assign idx_o = val << ext_i[10:9];
endmodule

// File: rtl/ea_step.sv
module ea_step #(
  parameter int DW  = 32,
  parameter int RIW = 3
) (
  input  logic [1:0]     size_i,
  input  logic [RIW-1:0] reg_i,
  output logic [DW-1:0]  step_o
);
  localparam logic [RIW-1:0] SP_IDX = '1;

  always_comb begin
    case (size_i)
      2'b00:   step_o = (reg_i == SP_IDX) ? DW'(2) : DW'(1);
      2'b01:   step_o = DW'(2);
      default: step_o = DW'(4);
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [5:0]        spec_i,
  input  logic [1:0]        size_i,
  input  logic [NREG*DW-1:0] dreg_i,
  input  logic [NREG*DW-1:0] areg_i,
  input  logic [DW-1:0]     pc_i,
  input  logic [15:0]       ext0_i,
  input  logic [15:0]       ext1_i,
  input  logic [15:0]       ext2_i,
  output logic              valid_o,
  output logic [DW-1:0]     addr_o,
  output logic              wb_en_o,
  output logic [RIW-1:0]    wb_reg_o,
  output logic [DW-1:0]     wb_data_o,
  output logic              cls_data_o,
  output logic              cls_mem_o,
  output logic              cls_ctrl_o,
  output logic              cls_alter_o,
  output logic              illegal_o
);
  ea_mode_e       mode;
  ea_class_t      cls_raw, cls_n;
  logic [RIW-1:0] rsel;
  logic [DW-1:0]  an, step, idx, base, bd, idx_addr, addr_n, wb_data_n;
  logic [DW-1:0]  d16, d8;
  logic           full, bad_ext, illegal_n, wb_en_n, is_idx;

  ea_decode u_decode (.spec_i(spec_i), .mode_o(mode), .cls_o(cls_raw));

  ea_index #(.DW(DW), .NREG(NREG)) u_index (
    .dreg_i(dreg_i), .areg_i(areg_i), .ext_i(ext0_i), .idx_o(idx)
  );

  ea_step #(.DW(DW), .RIW(RIW)) u_step (
    .size_i(size_i), .reg_i(rsel), .step_o(step)
  );

  assign rsel = spec_i[RIW-1:0];
  assign an   = areg_i[rsel*DW +: DW];
  assign d16  = {{(DW-16){ext0_i[15]}}, ext0_i};
  assign d8   = {{(DW-8){ext0_i[7]}}, ext0_i[7:0]};
  assign full = ext0_i[8];

  assign is_idx  = (mode == EA_IDX) || (mode == EA_PCIDX);
  assign bad_ext = is_idx && full && (ext0_i[5:4] == BD_RSVD);

  // full format: optional base suppression, sized base displacement
  always_comb begin
    base = (mode == EA_PCIDX) ? pc_i : an;
    if (full && ext0_i[7]) base = '0;
    if (!full) bd = d8;
    else begin
      case (ext0_i[5:4])
        BD_WORD: bd = {{(DW-16){ext1_i[15]}}, ext1_i};
        BD_LONG: bd = DW'({ext1_i, ext2_i});
        default: bd = '0;
      endcase
    end
  end

  assign idx_addr = base + bd + idx;

  always_comb begin
    addr_n    = '0;
    wb_en_n   = 1'b0;
    wb_data_n = '0;
    case (mode)
      EA_IND:     addr_n = an;
      EA_POSTINC: begin
        addr_n    = an;
        wb_en_n   = 1'b1;
        wb_data_n = an + step;
      end
      EA_PREDEC:  begin
        addr_n    = an - step;
        wb_en_n   = 1'b1;
        wb_data_n = an - step;
      end
      EA_DISP:    addr_n = an + d16;
      EA_IDX,
      EA_PCIDX:   addr_n = bad_ext ? '0 : idx_addr;
      EA_ABSW:    addr_n = d16;
      EA_ABSL:    addr_n = DW'({ext0_i, ext1_i});
      EA_PCDISP:  addr_n = pc_i + d16;
      default:    addr_n = '0;
    endcase
  end

  assign illegal_n = (mode == EA_BAD) || bad_ext;
  assign cls_n     = bad_ext ? '0 : cls_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      addr_o      <= '0;
      wb_en_o     <= 1'b0;
      wb_reg_o    <= '0;
      wb_data_o   <= '0;
      cls_data_o  <= 1'b0;
      cls_mem_o   <= 1'b0;
      cls_ctrl_o  <= 1'b0;
      cls_alter_o <= 1'b0;
      illegal_o   <= 1'b0;
    end else if (valid_i) begin
      valid_o     <= 1'b1;
      addr_o      <= addr_n;
      wb_en_o     <= wb_en_n;
      wb_reg_o    <= rsel;
      wb_data_o   <= wb_data_n;
      cls_data_o  <= cls_n.data;
      cls_mem_o   <= cls_n.mem;
      cls_ctrl_o  <= cls_n.ctrl;
      cls_alter_o <= cls_n.alter;
      illegal_o   <= illegal_n;
    end else begin
      valid_o   <= 1'b0;
      wb_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [5:0]    spec_i,
  input logic          valid_o,
  input logic [DW-1:0] addr_o,
  input logic          wb_en_o,
  input logic [DW-1:0] wb_data_o,
  input logic          cls_data_o,
  input logic          cls_mem_o,
  input logic          cls_ctrl_o,
  input logic          cls_alter_o,
  input logic          illegal_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !wb_en_o && !illegal_o)); // R11
  AST_WB_ONLY_STEP_MODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && spec_i[5:3] != 3'b011 && spec_i[5:3] != 3'b100) |=> !wb_en_o); // R4
  AST_PREDEC_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && spec_i[5:3] == 3'b100) |=> (wb_data_o == addr_o)); // R4
  AST_POSTINC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && spec_i[5:3] == 3'b011) |=>
      ((wb_data_o - addr_o) == DW'(1) || (wb_data_o - addr_o) == DW'(2) ||
       (wb_data_o - addr_o) == DW'(4))); // R5
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wb_en_o && !cls_data_o && !cls_mem_o && !cls_ctrl_o &&
                   !cls_alter_o && addr_o == '0)); // R2
  AST_REGDIR_NOMEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && spec_i[5:4] == 2'b00) |=> !cls_mem_o); // R10
  AST_PCREL_NOALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && spec_i[5:1] == 5'b11101) |=> !cls_alter_o); // R1
endmodule

bind ea_gen ea_gen_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .spec_i(spec_i),
  .valid_o(valid_o), .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_data_o(wb_data_o),
  .cls_data_o(cls_data_o), .cls_mem_o(cls_mem_o), .cls_ctrl_o(cls_ctrl_o),
  .cls_alter_o(cls_alter_o), .illegal_o(illegal_o)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [5:0]   spec = '0;
  logic [1:0]   size = '0;
  logic [255:0] dreg, areg;
  logic [31:0]  pc = '0;
  logic [15:0]  e0 = '0, e1 = '0, e2 = '0;
  logic         valid_o, wb_en_o, cd, cm, cc, ca, ill;
  logic [31:0]  addr_o, wb_data_o;
  logic [2:0]   wb_reg_o;
  logic [31:0]  dv [8];
  logic [31:0]  av [8];
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ea_gen u_ea_gen (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .spec_i(spec), .size_i(size),
    .dreg_i(dreg), .areg_i(areg), .pc_i(pc), .ext0_i(e0), .ext1_i(e1), .ext2_i(e2),
    .valid_o(valid_o), .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
    .wb_data_o(wb_data_o), .cls_data_o(cd), .cls_mem_o(cm), .cls_ctrl_o(cc),
    .cls_alter_o(ca), .illegal_o(ill)
  );

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic logic [31:0] sx8(input logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction

  // expected {data,mem,ctrl,alter} per category table
  function automatic logic [3:0] cls_exp(input logic [5:0] s);
    case (s[5:3])
      3'd0: return 4'b1001;
      3'd1: return 4'b0001;
      3'd3, 3'd4: return 4'b1101;
      3'd7: case (s[2:0])
              3'd0, 3'd1: return 4'b1111;
              3'd2, 3'd3: return 4'b1110;
              3'd4: return 4'b1100;
              default: return 4'b0000;
            endcase
      default: return 4'b1111;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] s, input logic [1:0] z,
                       input logic [15:0] x0, input logic [15:0] x1, input logic [15:0] x2);
    @(negedge clk);
    valid = 1'b1; spec = s; size = z; e0 = x0; e1 = x1; e2 = x2;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11", "reset valid_o", {31'd0, valid_o}, 32'd0);
    chk("R11", "reset addr_o", addr_o, 32'd0);
    chk("R11", "reset wb_en_o", {31'd0, wb_en_o}, 32'd0);
  endtask

  task automatic t_classes;
    for (int s = 0; s < 64; s++) begin
      apply(6'(s), 2'b10, 16'h0000, 16'h0000, 16'h0000);
      chk("R1", $sformatf("class spec=%02o", s), {28'd0, cd, cm, cc, ca}, {28'd0, cls_exp(6'(s))});
      chk("R2", $sformatf("illegal spec=%02o", s), {31'd0, ill},
          {31'd0, (s[5:3] == 3'd7 && s[2:0] > 3'd4)});
    end
    apply(6'o75, 2'b10, 16'h1234, 16'h0, 16'h0);
    chk("R2", "illegal addr", addr_o, 32'd0);
    chk("R2", "illegal wb_en", {31'd0, wb_en_o}, 32'd0);
  endtask

  task automatic t_indirect;
    apply(6'o23, 2'b10, 16'h0, 16'h0, 16'h0);
    chk("R3", "(A3)", addr_o, av[3]);
    apply(6'o53, 2'b10, 16'hFF00, 16'h0, 16'h0);
    chk("R3", "d16 negative", addr_o, av[3] + 32'hFFFF_FF00);
    apply(6'o54, 2'b10, 16'h7FFF, 16'h0, 16'h0);
    chk("R3", "d16 positive", addr_o, av[4] + 32'h0000_7FFF);
  endtask

  task automatic t_postinc;
    logic [31:0] st [3];
    st[0] = 1; st[1] = 2; st[2] = 4;
    for (int z = 0; z < 3; z++) begin
      apply(6'o32, 2'(z), 16'h0, 16'h0, 16'h0);
      chk("R4", "postinc addr", addr_o, av[2]);
      chk("R5", "postinc wb", wb_data_o, av[2] + st[z]);
      chk("R4", "postinc wb_en", {31'd0, wb_en_o}, 32'd1);
      chk("R4", "postinc wb_reg", {29'd0, wb_reg_o}, 32'd2);
    end
    apply(6'o37, 2'b00, 16'h0, 16'h0, 16'h0);
    chk("R5", "postinc byte A7", wb_data_o, av[7] + 32'd2);
  endtask

  task automatic t_predec;
    apply(6'o45, 2'b01, 16'h0, 16'h0, 16'h0);
    chk("R4", "predec word addr", addr_o, av[5] - 32'd2);
    chk("R4", "predec word wb", wb_data_o, av[5] - 32'd2);
    apply(6'o46, 2'b00, 16'h0, 16'h0, 16'h0);
    chk("R5", "predec byte A6", wb_data_o, av[6] - 32'd1);
    apply(6'o47, 2'b00, 16'h0, 16'h0, 16'h0);
    chk("R5", "predec byte A7", addr_o, av[7] - 32'd2);
    apply(6'o41, 2'b11, 16'h0, 16'h0, 16'h0);
    chk("R5", "predec long", wb_data_o, av[1] - 32'd4);
  endtask

  task automatic t_index_brief;
    // A1 base, A2.L*8, disp -4
    apply(6'o61, 2'b10, 16'hAEFC, 16'h0, 16'h0);
    chk("R6", "brief A-index long x8", addr_o, av[1] + (av[2] << 3) + 32'hFFFF_FFFC);
    // A1 base, D5.W*1, disp +0x10
    apply(6'o61, 2'b10, 16'h5010, 16'h0, 16'h0);
    chk("R6", "brief D-index word", addr_o, av[1] + 32'h10 + sx16(dv[5][15:0]));
    chk("R6", "indexed no wb", {31'd0, wb_en_o}, 32'd0);
  endtask

  task automatic t_index_full;
    // base suppressed, D5.W*4, word bd 0x0100
    apply(6'o63, 2'b10, 16'h55A0, 16'h0100, 16'h0);
    chk("R7", "full bs word bd", addr_o, 32'h100 + (sx16(dv[5][15:0]) << 2));
    // A0 base, D1.L*1, long bd
    apply(6'o60, 2'b10, 16'h1930, 16'h0012, 16'h3456);
    chk("R7", "full long bd", addr_o, av[0] + dv[1] + 32'h0012_3456);
    // null bd, D1.L
    apply(6'o60, 2'b10, 16'h1910, 16'hFFFF, 16'hFFFF);
    chk("R7", "full null bd", addr_o, av[0] + dv[1]);
    apply(6'o60, 2'b10, 16'h1900, 16'h0, 16'h0);
    chk("R2", "full bd rsvd illegal", {31'd0, ill}, 32'd1);
    chk("R2", "full bd rsvd class", {28'd0, cd, cm, cc, ca}, 32'd0);
  endtask

  task automatic t_pcrel;
    apply(6'o72, 2'b10, 16'hFFFE, 16'h0, 16'h0);
    chk("R8", "pc d16", addr_o, pc - 32'd2);
    apply(6'o73, 2'b10, 16'h5010, 16'h0, 16'h0);
    chk("R8", "pc brief index", addr_o, pc + 32'h10 + sx16(dv[5][15:0]));
    apply(6'o73, 2'b10, 16'hB920, 16'h8000, 16'h0);
    chk("R8", "pc full word bd A3.L", addr_o, pc + sx16(16'h8000) + av[3]);
  endtask

  task automatic t_abs;
    apply(6'o70, 2'b10, 16'h8000, 16'h0, 16'h0);
    chk("R9", "abs short", addr_o, sx16(16'h8000));
    apply(6'o71, 2'b10, 16'h00AB, 16'hCDEF, 16'h0);
    chk("R9", "abs long", addr_o, 32'h00AB_CDEF);
  endtask

  task automatic t_regdir;
    apply(6'o04, 2'b10, 16'h1234, 16'h0, 16'h0);
    chk("R10", "Dn addr", addr_o, 32'd0);
    chk("R10", "Dn mem", {31'd0, cm}, 32'd0);
    apply(6'o14, 2'b00, 16'h1234, 16'h0, 16'h0);
    chk("R10", "An wb_en", {31'd0, wb_en_o}, 32'd0);
    apply(6'o74, 2'b10, 16'h1234, 16'h5678, 16'h0);
    chk("R10", "imm addr", addr_o, 32'd0);
  endtask

  task automatic t_latency;
    apply(6'o32, 2'b10, 16'h0, 16'h0, 16'h0);
    chk("R11", "valid_o one cycle", {31'd0, valid_o}, 32'd1);
    valid = 1'b0;
    @(negedge clk);
    chk("R11", "valid_o drops", {31'd0, valid_o}, 32'd0);
    chk("R11", "wb_en drops", {31'd0, wb_en_o}, 32'd0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      dv[k] = 32'h0101_0000 * (k + 1) + 32'h20 * k;
      av[k] = 32'h2000_0000 + 32'h0000_0100 * k;
    end
    dv[5] = 32'h1234_F000;
    av[7] = 32'h0000_7FF0;
    for (int k = 0; k < 8; k++) begin
      dreg[k*32 +: 32] = dv[k];
      areg[k*32 +: 32] = av[k];
    end
    pc = 32'h0000_4000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_classes();
    t_indirect();
    t_postinc();
    t_predec();
    t_index_brief();
    t_index_full();
    t_pcrel();
    t_abs();
    t_regdir();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule